// File: doc/BRIEF.md
# Recursive Crosswise Unsigned Multiplier

This block multiplies two unsigned 24-bit operands and returns the full 48-bit product. It splits the work recursively. Each level cuts both operands into an upper and a lower half and forms four half-width products. It then adds them back together, with the two cross terms moved up by half the operand width and the upper-by-upper term moved up by the full width. The recursion ends at a 3x3 leaf cell. That cell is built only from AND-gate partial products, three half adders and three full adders. With the default width there are three levels above the leaves: 6, 12 and 24 bits.

Every adder in the tree is a parallel-prefix carry-lookahead adder. At each level the two cross products are summed into a result one bit wider than either term, so their carry survives into the shifted add. The outer-term products never overlap, so they are joined by concatenation and not by an adder. A parameter places a single register on the product, and it is on by default. With the register, the product appears one clock after the operands are sampled. It is cleared by an active-low asynchronous reset.

Top module: `vxmul`

## Requirements
- R1: With the output register enabled, `p_o` equals the full 48-bit unsigned product of the `a_i` and `b_i` values sampled at the previous rising clock edge, for any operand pair.
- R2: The product updates only at a rising clock edge: `p_o` keeps its old value when the operands change between edges, and holds steady while the operands stay unchanged.
- R3: While `rst_ni` is low, `p_o` is 0, whatever the operands. The reset takes effect at once, without waiting for a clock edge.
- R4: If either operand is zero, the product is zero.
- R5: If one operand is 1, the product equals the other operand, zero-extended to 48 bits.
- R6: All-ones operands (24'hFFFFFF times 24'hFFFFFF) give 48'hFFFFFE000001.
- R7: 24'hAAAAAA times 24'hDDDDDD gives 162629967156930 in decimal.
- R8: When the two cross products at a level add up to more than the operand width can hold (for example 24'hFFFFFF times 24'hFFFFFE), the extra carry reaches the product.
- R9: Power-of-two operands 2^i and 2^j give a product with only bit i+j set, for every i and j in 0..23.
- R10: Every pair of operands below 8 gives the correct product, which exercises the 3x3 leaf cell over all of its inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional product register |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the product |
| a_i | input | 24 | Unsigned multiplicand |
| b_i | input | 24 | Unsigned multiplier |
| p_o | output | 48 | Unsigned product |

## Verification
The bench targets the cases where a recursive split tends to go wrong. All-ones operands and cross sums that overflow catch a design that drops the cross-term carry. Such a design returns a product short by 2^(n+n/2) at the affected level. Walking single-bit operands catch a misplaced shift, which lands the set bit at the wrong position. The exhaustive sweep of small operands catches a wrong half or full adder in the leaf cell, which corrupts some 6-bit products. Directed checks of reset and between-edge operand changes catch a product that leaks through the register early or survives a reset.

// File: rtl/vxmul_pkg.sv
package vxmul_pkg;
  localparam int unsigned LEAF_W = 3;

  // {carry, sum}
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
    return {(x & y) | (z & (x ^ y)), x ^ y ^ z};
  endfunction
endpackage

// File: rtl/vxmul_leaf.sv
module vxmul_leaf
  import vxmul_pkg::*;
(
  input  logic [2:0] a_i,
  input  logic [2:0] b_i,
  output logic [5:0] p_o
);
  logic [2:0] pp0, pp1, pp2;
  logic [1:0] ha_c1, fa_c2, ha_c2, fa_c3, ha_c3, fa_c4;

  always_comb begin
    pp0 = a_i & {3{b_i[0]}};
    pp1 = a_i & {3{b_i[1]}};
    pp2 = a_i & {3{b_i[2]}};
    // column 1
    ha_c1 = half_add(pp0[1], pp1[0]);
    // column 2
    fa_c2 = full_add(pp0[2], pp1[1], pp2[0]);
    ha_c2 = half_add(fa_c2[0], ha_c1[1]);
    // column 3
    fa_c3 = full_add(pp1[2], pp2[1], fa_c2[1]);
    ha_c3 = half_add(fa_c3[0], ha_c2[1]);
    // column 4
    fa_c4 = full_add(pp2[2], fa_c3[1], ha_c3[1]);
    p_o = {fa_c4[1], fa_c4[0], ha_c3[0], ha_c2[0], ha_c1[0], pp0[0]};
  end
endmodule

// File: rtl/vxmul_cla.sv
module vxmul_cla #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gen_v, prp_v;

  // Kogge-Stone prefix; in-place update from the top bit down keeps old operands
  always_comb begin
    gen_v = a_i & b_i;
    prp_v = a_i ^ b_i;
    for (int l = 0; l < LVL; l++) begin
      for (int i = W - 1; i >= (1 << l); i--) begin
        gen_v[i] = gen_v[i] | (prp_v[i] & gen_v[i - (1 << l)]);
        prp_v[i] = prp_v[i] & prp_v[i - (1 << l)];
      end
    end
    if (W > 1) s_o = (a_i ^ b_i) ^ {gen_v[W-2:0], 1'b0};
    else       s_o = a_i ^ b_i;
  end
endmodule

// File: rtl/vxmul_node.sv
module vxmul_node
  import vxmul_pkg::*;
#(
  parameter int unsigned N = 24
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int unsigned H = N / 2;

  if (N == LEAF_W) begin : g_leaf
    vxmul_leaf u_leaf (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    logic [N-1:0]   lo_lo, hi_lo, lo_hi, hi_hi;
    logic [N:0]     cross_sum;
    logic [2*N-1:0] cross_sh;

    vxmul_node #(.N(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(lo_lo));
    vxmul_node #(.N(H)) u_hl (.a_i(a_i[N-1:H]), .b_i(b_i[H-1:0]), .p_o(hi_lo));
    vxmul_node #(.N(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[N-1:H]), .p_o(lo_hi));
    vxmul_node #(.N(H)) u_hh (.a_i(a_i[N-1:H]), .b_i(b_i[N-1:H]), .p_o(hi_hi));

    // one extra bit keeps the cross-term carry
    vxmul_cla #(.W(N+1)) u_cross (
      .a_i({1'b0, hi_lo}),
      .b_i({1'b0, lo_hi}),
      .s_o(cross_sum)
    );

    assign cross_sh = {{(N-H-1){1'b0}}, cross_sum, {H{1'b0}}};

    // outer products do not overlap: concatenate, then one add
    vxmul_cla #(.W(2*N)) u_merge (
      .a_i({hi_hi, lo_lo}),
      .b_i(cross_sh),
      .s_o(p_o)
    );
  end
endmodule

// File: rtl/vxmul.sv
module vxmul #(
  parameter int unsigned OP_W    = 24,  // LEAF_W times a power of two
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] p_o
);
  localparam int unsigned P_W = 2 * OP_W;

  logic [P_W-1:0] prod_c;

  vxmul_node #(.N(OP_W)) u_root (.a_i(a_i), .b_i(b_i), .p_o(prod_c));

  if (REG_OUT) begin : g_reg
    logic [P_W-1:0] prod_q;
    logic           live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q <= '0;
        live_q <= 1'b0;
      end else begin
        prod_q <= prod_c;
        live_q <= 1'b1;
      end
    end

    assign p_o = prod_q;

    assert_prod_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> p_o == ({{OP_W{1'b0}}, $past(a_i)} * {{OP_W{1'b0}}, $past(b_i)}));

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $stable(a_i) && $stable(b_i)) |=> $stable(p_o));

    assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && ($past(a_i) == '0 || $past(b_i) == '0)) |-> p_o == '0);

    assert_unit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(a_i) == OP_W'(1)) |-> p_o == {{OP_W{1'b0}}, $past(b_i)});

    assert_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && &$past(a_i) && &$past(b_i)) |-> p_o == {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1});
  end else begin : g_comb
    assign p_o = prod_c;
  end
endmodule

// File: tb/vxmul_test.sv
module vxmul_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [23:0] a_i, b_i;
  logic [47:0] p_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          dummy;

  vxmul uut (.clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [47:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
    longint unsigned x = 64'(a);
    longint unsigned y = 64'(b);
    return 48'(x * y);
  endfunction

  task automatic cmp(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // drive at a negedge, sample at the next negedge (one register)
  task automatic apply(input string req, input logic [23:0] a, input logic [23:0] b);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    @(negedge clk_i);
    cmp(req, p_o, ref_mul(a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    a_i = 24'd5;
    b_i = 24'd7;
    repeat (2) @(negedge clk_i);
    cmp("R3 reset", p_o, 48'd0);
    rst_ni = 1'b1;

    apply("R7 pattern", 24'hAAAAAA, 24'hDDDDDD);
    cmp("R7 decimal", p_o, 48'd162629967156930);
    apply("R6 ones", 24'hFFFFFF, 24'hFFFFFF);
    cmp("R6 literal", p_o, 48'hFFFFFE000001);
    apply("R8 cross carry", 24'hFFFFFF, 24'hFFFFFE);
    apply("R8 cross carry b", 24'hFFF7FF, 24'hFFFFFF);
    apply("R4 zero a", 24'h000000, 24'h123456);
    apply("R4 zero b", 24'hABCDEF, 24'h000000);
    apply("R5 unit a", 24'h000001, 24'hFEDCBA);
    apply("R5 unit b", 24'h89ABCD, 24'h000001);

    // R2: operand change between edges must not reach p_o
    apply("R2 setup", 24'h00F00F, 24'h0A0A0A);
    @(negedge clk_i);
    a_i = 24'h123456;
    b_i = 24'h654321;
    #1;
    cmp("R2 hold before edge", p_o, ref_mul(24'h00F00F, 24'h0A0A0A));
    @(negedge clk_i);
    cmp("R2 after edge", p_o, ref_mul(24'h123456, 24'h654321));
    @(negedge clk_i);
    cmp("R2 steady", p_o, ref_mul(24'h123456, 24'h654321));

    // R3: asynchronous reset mid-run
    #1;
    rst_ni = 1'b0;
    #1;
    cmp("R3 async clear", p_o, 48'd0);
    @(negedge clk_i);
    cmp("R3 held", p_o, 48'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 24; j++) begin
        apply("R9 powers", 24'd1 << i, 24'd1 << j);
        cmp("R9 single bit", p_o, 48'd1 << (i + j));
      end

    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        apply("R10 leaf sweep", 24'(x), 24'(y));

    dummy = $urandom(32'd24601);
    for (int k = 0; k < 3000; k++) begin
      logic [23:0] ra, rb;
      ra = 24'($urandom());
      rb = 24'($urandom());
      case (k % 4)
        1: ra = ra | 24'hFFF000;
        2: rb = rb & 24'($urandom());
        3: begin ra = ~ra & 24'hFFFFFF; rb = rb | 24'h000FFF; end
        default: ;
      endcase
      apply("R1 random", ra, rb);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule